// File: doc/BRIEF.md
# Tribit/Quadbit Constellation Level Mapper

This block sits at the front of an 8-PSK, 8-QAM or 16-QAM transmitter. It takes a serial bit stream, one bit per cycle in which `bit_valid` is high, and gathers it into groups. A group is three bits in the two 8-point modes and four bits in 16-QAM. When a group is complete, the block releases it in parallel and maps it to a pair of signed fixed-point amplitudes, one for the in-phase rail and one for the quadrature rail, which feed the product modulators downstream. The amplitudes are held until the next group completes. A one-cycle `sym_stb` marks the cycle in which a new pair appears.

In every mode, one bit of the group sets the sign of each rail and another bit sets its magnitude. The constellations differ only in how the magnitude bits are routed and which magnitude pair is used. In 8-PSK the quadrature rail gets the complement of the shared magnitude bit. In 8-QAM both rails get the shared bit unchanged. In 16-QAM each rail has its own magnitude bit.

A state machine in the splitter counts the position within a group. It has four states: `ST_B0` (empty, waiting for the first bit), `ST_B1` (one bit held), `ST_B2` (two bits held) and `ST_B3` (three bits held, 16-QAM only). Its transitions are:
- **start**: `ST_B0` to `ST_B1` when a bit arrives.
- **advance**: `ST_B1` to `ST_B2`, and `ST_B2` to `ST_B3` in 16-QAM.
- **emit**: to `ST_B0` when the last bit of a group arrives, from `ST_B2` in the 8-point modes or from `ST_B3` in 16-QAM.
- **abort**: from any non-empty state when `mode` differs from the mode latched at the start of the group. The machine goes to `ST_B0`, or to `ST_B1` if a bit arrives in that same cycle.
- **wait**: stay in the current state when no bit arrives.

Top module: `psk_qam_mapper`

## Requirements
- R1: `mode` 2'b00 selects 8-PSK and 2'b01 selects 8-QAM, both with three-bit groups. `mode` 2'b10 and 2'b11 both select 16-QAM, with four-bit groups. A bit is taken only in a cycle where `bit_valid` is high.
- R2: Within a group, the first bit taken is the Q sign bit and the second is the I sign bit. The third is the shared magnitude bit C in the 8-point modes, or the I magnitude bit in 16-QAM. In 16-QAM the fourth bit is the Q magnitude bit.
- R3: `amp_i` and `amp_q` are two's-complement codes with 10 fractional bits (12 bits wide by default). A sign bit of 1 gives a positive amplitude and a sign bit of 0 gives a negative one.
- R4: In 8-PSK, the I magnitude is 554 when C=0 and 1338 when C=1. The Q magnitude uses the complement of C, so it is 1338 when C=0 and 554 when C=1. For example, the group 000 gives I=-554 and Q=-1338.
- R5: In 8-QAM, both rails use C uninverted, with 554 for C=0 and 1338 for C=1. The two magnitudes are therefore always equal, and the group 000 gives -554 on both rails.
- R6: In 16-QAM, each rail's magnitude bit gives 841 when it is 1 and 225 when it is 0. The group 0000 gives -225 on both rails.
- R7: `sym_stb` is high for exactly one cycle: the cycle after the clock edge that takes the last bit of a group. The new amplitudes are present in that same cycle. A group completed back to back with the previous one gets its own pulse.
- R8: Between strobes, `amp_i` and `amp_q` hold their last values, whatever `bit_valid`, `bit_in` or `mode` do.
- R9: Suppose `mode` differs from the value it had when the current group started, while that group is only partly filled. Then the partial group is dropped and produces no strobe. A bit presented in that same cycle becomes the first bit of a new group in the new mode.
- R10: After reset, `amp_i` and `amp_q` are 0, `sym_stb` is low and the splitter is empty.
- R11: Cycles with `bit_valid` low between the bits of a group leave the group and its result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a data bit this cycle |
| bit_in | input | 1 | Serial data bit |
| mode | input | 2 | Constellation select (00 8-PSK, 01 8-QAM, 1x 16-QAM) |
| amp_i | output | AMP_W | Signed in-phase amplitude code |
| amp_q | output | AMP_W | Signed quadrature amplitude code |
| sym_stb | output | 1 | One-cycle pulse: new amplitude pair valid |

## Verification
Two events can land on the same clock edge: an abort caused by a mode change, and a new data bit that must then start the next group. The bench provokes this by switching `mode` in the same cycle that it presents the next bit, partway through an 8-PSK group. It then completes a 16-QAM group and judges the result in two ways. First, exactly one strobe must appear. Second, that strobe must carry the 16-QAM levels of the four new bits; a wrongly completed 8-PSK group would show up as an extra pulse with a 554-family magnitude. The bench also overlaps a strobe with the first bit of the following group to confirm that the two groups stay separate.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        ST_B0 = 2'd0,
        ST_B1 = 2'd1,
        ST_B2 = 2'd2,
        ST_B3 = 2'd3
    } split_state_t;

    localparam logic [1:0] MODE_8PSK = 2'b00;
    localparam logic [1:0] MODE_8QAM = 2'b01;

    // held group, already routed for the two converters
    typedef struct packed {
        logic loaded;
        logic wide;
        logic sign_i;
        logic mag_i;
        logic sign_q;
        logic mag_q;
    } group_t;

    function automatic logic is_wide(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/group_splitter.sv
module group_splitter
    import mapper_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic [1:0] mode,
    output group_t     grp,
    output logic       grp_vld
);

    split_state_t state, nxt;
    logic [1:0]   grp_mode;
    logic         sh_q, sh_i, sh_x;
    logic         abort;

    assign abort = (state != ST_B0) && (mode != grp_mode);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_B0;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_B0: if (bit_valid) nxt = ST_B1;
            ST_B1: begin
                if (abort)          nxt = bit_valid ? ST_B1 : ST_B0;
                else if (bit_valid) nxt = ST_B2;
            end
            ST_B2: begin
                if (abort)          nxt = bit_valid ? ST_B1 : ST_B0;
                else if (bit_valid) nxt = is_wide(grp_mode) ? ST_B3 : ST_B0;
            end
            ST_B3: begin
                if (abort)          nxt = bit_valid ? ST_B1 : ST_B0;
                else if (bit_valid) nxt = ST_B0;
            end
        endcase
    end

    // data capture and group release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp      <= '0;
            grp_vld  <= 1'b0;
            grp_mode <= MODE_8PSK;
            sh_q     <= 1'b0;
            sh_i     <= 1'b0;
            sh_x     <= 1'b0;
        end else begin
            grp_vld <= 1'b0;
            if (bit_valid) begin
                if (state == ST_B0 || abort) begin
                    sh_q     <= bit_in;
                    grp_mode <= mode;
                end else begin
                    unique case (state)
                        ST_B1: sh_i <= bit_in;
                        ST_B2: begin
                            if (is_wide(grp_mode)) begin
                                sh_x <= bit_in;
                            end else begin
                                grp_vld    <= 1'b1;
                                grp.loaded <= 1'b1;
                                grp.wide   <= 1'b0;
                                grp.sign_q <= sh_q;
                                grp.sign_i <= sh_i;
                                grp.mag_i  <= bit_in;
                                grp.mag_q  <= (grp_mode == MODE_8QAM) ? bit_in : ~bit_in;
                            end
                        end
                        ST_B3: begin
                            grp_vld    <= 1'b1;
                            grp.loaded <= 1'b1;
                            grp.wide   <= 1'b1;
                            grp.sign_q <= sh_q;
                            grp.sign_i <= sh_i;
                            grp.mag_i  <= sh_x;
                            grp.mag_q  <= bit_in;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/amp_level.sv
module amp_level #(
    parameter int AMP_W  = 12,
    parameter int LO8    = 554,
    parameter int HI8    = 1338,
    parameter int LO16   = 225,
    parameter int HI16   = 841
) (
    input  logic                    loaded,
    input  logic                    wide,
    input  logic                    sign,
    input  logic                    mag,
    output logic signed [AMP_W-1:0] amp
);

    logic signed [AMP_W-1:0] size;

    always_comb begin
        unique case ({wide, mag})
            2'b00:   size = AMP_W'(LO8);
            2'b01:   size = AMP_W'(HI8);
            2'b10:   size = AMP_W'(LO16);
            default: size = AMP_W'(HI16);
        endcase
        if (!loaded)   amp = '0;
        else if (sign) amp = size;
        else           amp = -size;
    end

endmodule

// File: rtl/psk_qam_mapper.sv
module psk_qam_mapper
    import mapper_pkg::*;
#(
    parameter int AMP_W  = 12,
    parameter int FRAC_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_valid,
    input  logic                    bit_in,
    input  logic [1:0]              mode,
    output logic signed [AMP_W-1:0] amp_i,
    output logic signed [AMP_W-1:0] amp_q,
    output logic                    sym_stb
);

    localparam real SCALE = 2.0 ** FRAC_W;
    localparam int  LO8   = $rtoi(0.541 * SCALE + 0.5);
    localparam int  HI8   = $rtoi(1.307 * SCALE + 0.5);
    localparam int  LO16  = $rtoi(0.22  * SCALE + 0.5);
    localparam int  HI16  = $rtoi(0.821 * SCALE + 0.5);
    localparam int  NCH   = 2;

    group_t grp;
    logic   grp_vld;
    logic   ch_sign [NCH];
    logic   ch_mag  [NCH];
    logic signed [AMP_W-1:0] ch_amp [NCH];

    group_splitter u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .mode      (mode),
        .grp       (grp),
        .grp_vld   (grp_vld)
    );

    assign ch_sign[0] = grp.sign_i;
    assign ch_mag[0]  = grp.mag_i;
    assign ch_sign[1] = grp.sign_q;
    assign ch_mag[1]  = grp.mag_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_conv
        amp_level #(
            .AMP_W (AMP_W),
            .LO8   (LO8),
            .HI8   (HI8),
            .LO16  (LO16),
            .HI16  (HI16)
        ) u_conv (
            .loaded (grp.loaded),
            .wide   (grp.wide),
            .sign   (ch_sign[ch]),
            .mag    (ch_mag[ch]),
            .amp    (ch_amp[ch])
        );
    end

    assign amp_i   = ch_amp[0];
    assign amp_q   = ch_amp[1];
    assign sym_stb = grp_vld;

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int AMP_W  = 12,
    parameter int FRAC_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sym_stb,
    input logic signed [AMP_W-1:0] amp_i,
    input logic signed [AMP_W-1:0] amp_q
);

    localparam real SCALE = 2.0 ** FRAC_W;
    localparam logic [AMP_W-1:0] M_LO8  = AMP_W'($rtoi(0.541 * SCALE + 0.5));
    localparam logic [AMP_W-1:0] M_HI8  = AMP_W'($rtoi(1.307 * SCALE + 0.5));
    localparam logic [AMP_W-1:0] M_LO16 = AMP_W'($rtoi(0.22  * SCALE + 0.5));
    localparam logic [AMP_W-1:0] M_HI16 = AMP_W'($rtoi(0.821 * SCALE + 0.5));

    logic [AMP_W-1:0] mag_i, mag_q;
    logic             fam16_i, fam16_q, legal_i, legal_q;

    assign mag_i   = amp_i[AMP_W-1] ? AMP_W'(-amp_i) : amp_i;
    assign mag_q   = amp_q[AMP_W-1] ? AMP_W'(-amp_q) : amp_q;
    assign fam16_i = (mag_i == M_LO16) || (mag_i == M_HI16);
    assign fam16_q = (mag_q == M_LO16) || (mag_q == M_HI16);
    assign legal_i = fam16_i || (mag_i == M_LO8) || (mag_i == M_HI8);
    assign legal_q = fam16_q || (mag_q == M_LO8) || (mag_q == M_HI8);

    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> !sym_stb);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |-> ($stable(amp_i) && $stable(amp_q)));

    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |-> (amp_i != 0 && amp_q != 0));

    p_mag_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |-> (legal_i && legal_q));

    p_family_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |-> (fam16_i == fam16_q));

endmodule

bind psk_qam_mapper mapper_checker #(.AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_stb (sym_stb),
    .amp_i   (amp_i),
    .amp_q   (amp_q)
);

// File: tb/tb_psk_qam_mapper.sv
module tb_psk_qam_mapper;

    localparam int AMP_W = 12;
    localparam int NVEC  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic [1:0] mode = 2'b00;
    logic signed [AMP_W-1:0] amp_i, amp_q;
    logic sym_stb;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    psk_qam_mapper dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .mode(mode), .amp_i(amp_i), .amp_q(amp_q), .sym_stb(sym_stb)
    );

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n && sym_stb) stb_cnt <= stb_cnt + 1;

    // {mode, bits first..fourth, expected I, expected Q}
    localparam logic [29:0] VEC [NVEC] = '{
        {2'b00, 4'b0000, 12'(-554),  12'(-1338)},
        {2'b00, 4'b1000, 12'(-554),  12'(1338)},
        {2'b00, 4'b0110, 12'(1338),  12'(-554)},
        {2'b00, 4'b1110, 12'(1338),  12'(554)},
        {2'b01, 4'b0000, 12'(-554),  12'(-554)},
        {2'b01, 4'b1010, 12'(-1338), 12'(1338)},
        {2'b10, 4'b0000, 12'(-225),  12'(-225)},
        {2'b10, 4'b1110, 12'(841),   12'(225)},
        {2'b10, 4'b0101, 12'(225),   12'(-841)},
        {2'b11, 4'b1011, 12'(-841),  12'(841)}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic [1:0] m, input logic b);
        @(negedge clk);
        mode = m; bit_valid = 1'b1; bit_in = b;
    endtask

    task automatic idle(input logic [1:0] m);
        @(negedge clk);
        mode = m; bit_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 amp_i", int'(amp_i), 0);
        check("R10 amp_q", int'(amp_q), 0);
        check("R10 sym_stb", int'(sym_stb), 0);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] m;
            int n;
            m = VEC[v][29:28];
            n = m[1] ? 4 : 3;
            for (int k = 0; k < n; k++) put_bit(m, VEC[v][27-k]);
            idle(m);
            check("R7 strobe", int'(sym_stb), 1);
            check(m[1] ? "R1 R2 R6 amp_i" : (m[0] ? "R1 R2 R5 amp_i" : "R1 R2 R4 amp_i"),
                  int'(amp_i), int'($signed(VEC[v][23:12])));
            check(m[1] ? "R3 R6 amp_q" : (m[0] ? "R3 R5 amp_q" : "R3 R4 amp_q"),
                  int'(amp_q), int'($signed(VEC[v][11:0])));
            idle(m);
            check("R7 pulse width", int'(sym_stb), 0);
            check("R8 hold amp_i", int'(amp_i), int'($signed(VEC[v][23:12])));
        end

        // R11 gaps inside a group: 8-PSK Q=1 I=0 C=1
        put_bit(2'b00, 1'b1); idle(2'b00); idle(2'b00);
        put_bit(2'b00, 1'b0); idle(2'b00);
        put_bit(2'b00, 1'b1); idle(2'b00);
        check("R11 strobe", int'(sym_stb), 1);
        check("R11 amp_i", int'(amp_i), -1338);
        check("R11 amp_q", int'(amp_q), 554);
        idle(2'b00);

        // R9 abort with a bit in the same cycle
        base = stb_cnt;
        put_bit(2'b00, 1'b1); put_bit(2'b00, 1'b1);
        put_bit(2'b10, 1'b0); put_bit(2'b10, 1'b0);
        put_bit(2'b10, 1'b0); put_bit(2'b10, 1'b0);
        idle(2'b10);
        check("R9 strobe", int'(sym_stb), 1);
        check("R9 amp_i", int'(amp_i), -225);
        check("R9 amp_q", int'(amp_q), -225);
        idle(2'b10);
        check("R9 single strobe", stb_cnt - base, 1);

        // R9 abort with no bit: partial 8-QAM dropped, then 8-PSK Q=0 I=1 C=1
        base = stb_cnt;
        put_bit(2'b01, 1'b1);
        idle(2'b00);
        put_bit(2'b00, 1'b0); put_bit(2'b00, 1'b1); put_bit(2'b00, 1'b1);
        idle(2'b00);
        check("R9 idle abort amp_i", int'(amp_i), 1338);
        check("R9 idle abort amp_q", int'(amp_q), -554);
        idle(2'b00);
        check("R9 idle abort count", stb_cnt - base, 1);

        // R7 back-to-back 8-QAM groups
        put_bit(2'b01, 1'b1); put_bit(2'b01, 1'b1); put_bit(2'b01, 1'b1);
        put_bit(2'b01, 1'b0);
        check("R7 first strobe", int'(sym_stb), 1);
        check("R5 first amp_q", int'(amp_q), 1338);
        put_bit(2'b01, 1'b0);
        check("R7 gap low", int'(sym_stb), 0);
        put_bit(2'b01, 1'b0);
        idle(2'b01);
        check("R7 second strobe", int'(sym_stb), 1);
        check("R5 second amp_i", int'(amp_i), -554);

        // R8 hold while inputs wander with no valid bits
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            mode = 2'(k); bit_in = k[0]; bit_valid = 1'b0;
            check("R8 idle amp_q", int'(amp_q), -554);
            check("R8 idle strobe", int'(sym_stb), 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule